// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns one transmit request into a byte stream that a MAC can send. A one-cycle `start` pulse captures the destination station address, the local station address and a 16-bit EtherType. The block then sends the 14-byte header, passes the payload bytes through from a valid/ready source, and appends zero bytes when the frame would be shorter than the minimum size. It counts every byte it sends. Once the last byte has gone out, it presents a descriptor word: an ownership flag together with the frame length, masked to 12 bits. The word stays up until the consumer hands the frame back.

The consumer returns a status word on `cmp_valid`/`cmp_status`. A status that still has the ownership flag set is ignored. A status with the flag cleared ends the frame and raises `done` for one cycle. `tx_err` is set when the packet-OK flag in that status is clear. A cycle-counting watchdog covers a consumer that never hands the frame back: after `TIMEOUT_CYC` cycles of waiting it ends the frame with `tx_timeout` set.

The controller has five states. IDLE goes to HDR on `start`. HDR goes to PAY after the fourteenth header byte. PAY goes to WAIT on the last payload byte when the frame has reached the minimum size, and to PAD on the last payload byte when it is still short. PAD goes to WAIT on the byte that brings the frame to the minimum size. WAIT goes back to IDLE on a released completion or on watchdog expiry.

Top module: `eth_tx_framer`

## Requirements
- R1: Every frame begins with the 6 destination bytes, then the 6 source bytes, then the 2 EtherType bytes, each field sent most significant byte first (the first byte is `dst_addr[47:40]`, the fourteenth is `eth_type[7:0]`).
- R2: After the header, the payload bytes appear on `out_data` unchanged and in their arrival order. `pay_ready` is high only in the payload phase and only while `out_ready` is high.
- R3: When header plus payload is shorter than `MIN_FRAME` (60) bytes, zero bytes follow the payload up to exactly 60 bytes, and `out_last` marks the 60th byte.
- R4: When header plus payload is at least 60 bytes, no padding is added, and `out_last` marks the last payload byte.
- R5: While the frame waits for completion, `desc_valid` is high and `desc_word` has bit 31 set, bits 30..12 clear, and bits 11..0 holding the number of bytes sent, padding included.
- R6: The length field is the total byte count modulo 4096.
- R7: A completion with `cmp_status[31]` set is ignored. A completion with bit 31 clear ends the wait, and `done` is high for exactly the one cycle that follows.
- R8: At the completion that ends a frame, `tx_err` becomes the inverse of `cmp_status[27]` and holds until the next `start`.
- R9: If no released completion arrives within `TIMEOUT_CYC` cycles of waiting, the frame ends with `done` and `tx_timeout` set. `tx_timeout` and `tx_err` are never high together.
- R10: While `out_ready` is low, no byte is consumed: the frame content is unaffected by stalls.
- R11: `start` has no effect while `busy` is high. The latched addresses are kept, and no second frame follows.
- R12: After reset the block is idle: `busy`, `out_valid`, `desc_valid`, `done`, `tx_err` and `tx_timeout` are low, and `out_valid` and `desc_valid` stay low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (sampled in IDLE only) |
| dst_addr | input | 48 | Destination station address |
| src_addr | input | 48 | Local station address |
| eth_type | input | 16 | EtherType |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte present |
| pay_last | input | 1 | Marks the final payload byte |
| pay_ready | output | 1 | Payload byte accepted this cycle |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte present |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Downstream accepts a byte |
| desc_valid | output | 1 | Descriptor word presented, awaiting completion |
| desc_word | output | 32 | Ownership flag and 12-bit length |
| cmp_valid | input | 1 | Completion status present |
| cmp_status | input | 32 | Returned status (bit 31 owned, bit 27 packet OK) |
| done | output | 1 | One-cycle end-of-frame pulse |
| tx_err | output | 1 | Last frame completed without packet OK |
| tx_timeout | output | 1 | Last frame ended by the watchdog |
| busy | output | 1 | A frame is in progress |

## Verification
A wrong header index or a wrong byte count shows up on `out_data` within the frame it affects. It appears as a displaced header byte, a missing or extra pad byte, or `out_last` on the wrong position, all visible before `desc_valid` rises. A counter that is off by one also shows up in the length field as soon as the descriptor word appears. A fault in the wait state shows up within one cycle of a completion: `done` is missing or late, `busy` stays high, or a frame that still owned is accepted. A fault in the watchdog shows up at cycle `TIMEOUT_CYC` of the wait, where `tx_timeout` rises one cycle early or late.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_WAIT
    } tx_state_e;

    localparam int HDR_BYTES = 14;
    localparam int OWN_BIT   = 31;
    localparam int OK_BIT    = 27;
    localparam int LEN_W     = 12;
endpackage

// File: rtl/ethtx_hdr_sel.sv
module ethtx_hdr_sel
    import ethtx_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int TYPE_W = 16
) (
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] src,
    input  logic [TYPE_W-1:0] etype,
    input  logic [3:0]        idx,
    output logic [7:0]        hdr_byte
);
    localparam int HDR_W = 2 * ADDR_W + TYPE_W;

    logic [HDR_W-1:0] hdr_vec;

    assign hdr_vec = {dst, src, etype};

    // Byte 0 is the most significant byte of the destination address.
    always_comb begin
        hdr_byte = 8'h00;
        for (int b = 0; b < HDR_BYTES; b++) begin
            if (idx == 4'(b)) begin
                hdr_byte = hdr_vec[HDR_W-1-8*b -: 8];
            end
        end
    end
endmodule

// File: rtl/ethtx_watchdog.sv
module ethtx_watchdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import ethtx_pkg::*;
#(
    parameter int MIN_FRAME   = 60,
    parameter int TIMEOUT_CYC = 200_000_000,
    parameter int CNT_W       = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [47:0] dst_addr,
    input  logic [47:0] src_addr,
    input  logic [15:0] eth_type,
    input  logic [7:0]  pay_data,
    input  logic        pay_valid,
    input  logic        pay_last,
    output logic        pay_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    output logic        out_last,
    input  logic        out_ready,
    output logic        desc_valid,
    output logic [31:0] desc_word,
    input  logic        cmp_valid,
    input  logic [31:0] cmp_status,
    output logic        done,
    output logic        tx_err,
    output logic        tx_timeout,
    output logic        busy
);
    localparam logic [CNT_W:0] MIN_CNT  = (CNT_W+1)'(MIN_FRAME);
    localparam logic [3:0]     HDR_LAST = 4'(HDR_BYTES - 1);

    tx_state_e        state, state_nxt;
    logic [3:0]       hdr_idx;
    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W:0]   cnt_inc;
    logic [47:0]      dst_q, src_q;
    logic [15:0]      type_q;
    logic [7:0]       hdr_byte;
    logic             fire;
    logic             reach_min;
    logic             rel_evt;
    logic             wd_expire;
    logic             done_q, err_q, to_q;

    ethtx_hdr_sel #(.ADDR_W(48), .TYPE_W(16)) u_hdr (
        .dst      (dst_q),
        .src      (src_q),
        .etype    (type_q),
        .idx      (hdr_idx),
        .hdr_byte (hdr_byte)
    );

    ethtx_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_WAIT),
        .expire (wd_expire)
    );

    assign fire      = out_valid && out_ready;
    assign cnt_inc   = {1'b0, byte_cnt} + 1'b1;
    assign reach_min = (cnt_inc >= MIN_CNT);
    assign rel_evt   = cmp_valid && !cmp_status[OWN_BIT];

    // Next-state selection.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_HDR;
            ST_HDR:  if (fire && hdr_idx == HDR_LAST) state_nxt = ST_PAY;
            ST_PAY:  if (fire && pay_last) state_nxt = reach_min ? ST_WAIT : ST_PAD;
            ST_PAD:  if (fire && reach_min) state_nxt = ST_WAIT;
            ST_WAIT: if (rel_evt || wd_expire) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hdr_idx  <= '0;
            byte_cnt <= '0;
            dst_q    <= '0;
            src_q    <= '0;
            type_q   <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            to_q     <= 1'b0;
        end else begin
            state  <= state_nxt;
            done_q <= (state == ST_WAIT) && (state_nxt == ST_IDLE);
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        dst_q    <= dst_addr;
                        src_q    <= src_addr;
                        type_q   <= eth_type;
                        hdr_idx  <= '0;
                        byte_cnt <= '0;
                        err_q    <= 1'b0;
                        to_q     <= 1'b0;
                    end
                end
                ST_HDR: begin
                    if (fire) begin
                        hdr_idx  <= hdr_idx + 1'b1;
                        byte_cnt <= cnt_inc[CNT_W-1:0];
                    end
                end
                ST_PAY, ST_PAD: begin
                    if (fire) byte_cnt <= cnt_inc[CNT_W-1:0];
                end
                ST_WAIT: begin
                    if (rel_evt) begin
                        err_q <= !cmp_status[OK_BIT];
                    end else if (wd_expire) begin
                        to_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        out_valid  = 1'b0;
        out_data   = 8'h00;
        out_last   = 1'b0;
        pay_ready  = 1'b0;
        desc_valid = 1'b0;
        desc_word  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_byte;
            end
            ST_PAY: begin
                out_valid = pay_valid;
                out_data  = pay_data;
                out_last  = pay_last && reach_min;
                pay_ready = out_ready;
            end
            ST_PAD: begin
                out_valid = 1'b1;
                out_last  = reach_min;
            end
            ST_WAIT: begin
                desc_valid         = 1'b1;
                desc_word[OWN_BIT] = 1'b1;
                desc_word[LEN_W-1:0] = byte_cnt[LEN_W-1:0];
            end
            default: ;
        endcase
    end

    assign done       = done_q;
    assign tx_err     = err_q;
    assign tx_timeout = to_q;
    assign busy       = (state != ST_IDLE);
endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        out_valid,
    input logic        out_ready,
    input logic        pay_ready,
    input logic        desc_valid,
    input logic [31:0] desc_word,
    input logic        done,
    input logic        tx_err,
    input logic        tx_timeout,
    input logic        busy
);
    // R2
    pay_ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> out_ready);

    // R5
    desc_word_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_word[31] && desc_word[30:12] == 19'd0));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!desc_valid && !busy));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_err) |-> done);

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_err && tx_timeout));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !desc_valid));
endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .pay_ready  (pay_ready),
    .desc_valid (desc_valid),
    .desc_word  (desc_word),
    .done       (done),
    .tx_err     (tx_err),
    .tx_timeout (tx_timeout),
    .busy       (busy)
);

// File: tb/sim_eth_tx_framer.sv
module sim_eth_tx_framer;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] dst_addr = 48'h0A1B2C3D4E5F;
    logic [47:0] src_addr = 48'h102030405060;
    logic [15:0] eth_type = 16'h0806;
    logic [7:0]  pay_data = 8'h00;
    logic        pay_valid = 1'b0;
    logic        pay_last = 1'b0;
    logic        pay_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        desc_valid;
    logic [31:0] desc_word;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_status = 32'h0;
    logic        done;
    logic        tx_err;
    logic        tx_timeout;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] cap [0:16383];
    int cap_n = 0;
    int last_at = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_tx_framer #(.MIN_FRAME(60), .TIMEOUT_CYC(TMO), .CNT_W(16)) u0 (
        .clk, .rst_n, .start, .dst_addr, .src_addr, .eth_type,
        .pay_data, .pay_valid, .pay_last, .pay_ready,
        .out_data, .out_valid, .out_last, .out_ready,
        .desc_valid, .desc_word, .cmp_valid, .cmp_status,
        .done, .tx_err, .tx_timeout, .busy
    );

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            cap[cap_n] <= out_data;
            if (out_last) last_at <= cap_n;
            cap_n <= cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int i, input int seed);
        return 8'((i * 7 + seed) & 8'hFF);
    endfunction

    function automatic logic [7:0] hbyte(input int i, input logic [47:0] d);
        logic [111:0] h;
        h = {d, src_addr, eth_type};
        return h[111 - 8*i -: 8];
    endfunction

    task automatic send(input int n, input int seed);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pay_valid = 1'b1;
            pay_data  = pbyte(i, seed);
            pay_last  = (i == n - 1);
            do begin
                @(negedge clk);
                #1;
            end while (!pay_ready);
            @(posedge clk);
            #1;
        end
        pay_valid = 1'b0;
        pay_last  = 1'b0;
        while (!desc_valid) @(negedge clk);
    endtask

    task automatic verify_frame(input int base, input int n, input int seed,
                                input int total, input logic [47:0] d, input string rq_pad);
        int bad_h = 0, bad_p = 0, bad_z = 0;
        for (int i = 0; i < 14; i++) if (cap[base+i] !== hbyte(i, d)) bad_h++;
        // R1 header order
        check(bad_h == 0, "R1 header bytes", bad_h, 0);
        for (int i = 0; i < n; i++) if (cap[base+14+i] !== pbyte(i, seed)) bad_p++;
        // R2 payload pass-through (also R10 when stalls were applied)
        check(bad_p == 0, "R2 payload bytes", bad_p, 0);
        for (int i = 14 + n; i < total; i++) if (cap[base+i] !== 8'h00) bad_z++;
        // R3 zero padding
        check(bad_z == 0, "R3 pad bytes zero", bad_z, 0);
        check(cap_n - base == total, {rq_pad, " byte count"}, cap_n - base, total);
        check(last_at - base == total - 1, {rq_pad, " last marker"}, last_at - base, total - 1);
    endtask

    task automatic complete(input logic [31:0] st, input bit exp_err);
        @(negedge clk);
        cmp_valid  = 1'b1;
        cmp_status = st;
        @(negedge clk);
        cmp_valid = 1'b0;
        // R7 released completion ends the frame
        check(done && !busy && !desc_valid, "R7 done after release", {done, busy, desc_valid}, 3'b100);
        // R8 error flag from packet-OK bit
        check(tx_err == exp_err, "R8 tx_err", tx_err, exp_err);
        @(negedge clk);
        check(!done, "R7 done one cycle", done, 0);
    endtask

    task automatic t_reset();
        // R12 reset state
        check({busy, out_valid, desc_valid, done, tx_err, tx_timeout} == 6'b0,
              "R12 reset outputs", {busy, out_valid, desc_valid, done, tx_err, tx_timeout}, 0);
    endtask

    task automatic t_short_stalled();
        int base = cap_n;
        fork
            send(10, 3);
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    out_ready = (k % 3 != 1);
                end
                out_ready = 1'b1;
            end
        join
        @(negedge clk);
        verify_frame(base, 10, 3, 60, dst_addr, "R3");
        // R5 descriptor word
        check(desc_word == 32'h8000_003C, "R5 desc word short", desc_word, 32'h8000_003C);
        complete(32'h0800_0000, 1'b0);
    endtask

    task automatic t_long();
        int base = cap_n;
        send(100, 11);
        @(negedge clk);
        verify_frame(base, 100, 11, 114, dst_addr, "R4");
        check(desc_word == 32'h8000_0072, "R5 desc word long", desc_word, 32'h8000_0072);
        // R7 owned completion ignored
        @(negedge clk);
        cmp_valid  = 1'b1;
        cmp_status = 32'h8800_0000;
        @(negedge clk);
        cmp_valid = 1'b0;
        check(desc_valid && !done, "R7 owned status ignored", {desc_valid, done}, 2'b10);
        complete(32'h0000_0000, 1'b1);
    endtask

    task automatic t_exact();
        int base = cap_n;
        send(46, 5);
        @(negedge clk);
        verify_frame(base, 46, 5, 60, dst_addr, "R4");
        complete(32'h0800_0000, 1'b0);
    endtask

    task automatic t_mask();
        int base = cap_n;
        send(4100, 9);
        @(negedge clk);
        check(cap_n - base == 4114, "R6 byte count", cap_n - base, 4114);
        // R6 masked length 4114 mod 4096
        check(desc_word == 32'h8000_0012, "R6 desc length masked", desc_word, 32'h8000_0012);
        complete(32'h0800_0000, 1'b0);
    endtask

    task automatic t_timeout();
        send(20, 1);
        for (int k = 1; k < TMO; k++) @(negedge clk);
        // R9 still waiting at cycle TMO
        check(desc_valid && !tx_timeout, "R9 no early timeout", {desc_valid, tx_timeout}, 2'b10);
        @(negedge clk);
        check(done && tx_timeout && !tx_err && !busy, "R9 timeout flagged",
              {done, tx_timeout, tx_err, busy}, 4'b1100);
    endtask

    task automatic t_busy_start();
        int base = cap_n;
        logic [47:0] orig = dst_addr;
        fork
            send(20, 2);
            begin
                repeat (20) @(negedge clk);
                dst_addr = 48'hFFEEDDCCBBAA;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        @(negedge clk);
        verify_frame(base, 20, 2, 60, orig, "R11");
        complete(32'h0800_0000, 1'b0);
        repeat (4) @(negedge clk);
        // R11 no second frame from a start seen while busy
        check(!busy && cap_n - base == 60, "R11 start ignored while busy", cap_n - base, 60);
        dst_addr = orig;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_short_stalled();
                t_long();
                t_exact();
                t_mask();
                t_timeout();
                t_busy_start();
            end
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule